// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Unit

This block sits on the CPU side of a game-cartridge memory mapper. It watches CPU writes to the upper half of the address space (8000-FFFF) and keeps the mapper's configuration in registers: two switchable 8-bit PRG bank numbers, a PRG swap-mode flag, a 2-bit nametable mirroring code and eight 9-bit CHR bank numbers, one for each 1 KiB slice of the pattern space. Each 9-bit CHR number is written in two pieces, a 4-bit low nibble and a 5-bit high part, at adjacent even and odd addresses.

Two combinational lookups use these registers. The CPU address selects one of four 8 KiB PRG windows and yields the ROM bank for that window. The PPU address selects one of the eight CHR registers and yields the 1 KiB CHR bank. The swap flag exchanges the two windows that the first switchable PRG register and the second-to-last ROM bank occupy. The topmost window always holds the last ROM bank. Interrupt counting, ROM storage and bus timing are handled elsewhere.

Top module: `cart_bank_unit`

## Requirements
- R1: After reset, both switchable PRG registers, the swap flag, the mirroring code and all eight CHR bank numbers are zero. So `prg_bank` is 0 for 8000-9FFF and A000-BFFF, PRG_ROM_BANKS-2 for C000-DFFF and PRG_ROM_BANKS-1 for E000-FFFF. `chr_bank` and `mirror` are 0.
- R2: A write to register address 8000 loads `cpu_data[7:0]` into the first PRG register on the clock edge where `cpu_wr` is high. With the swap flag clear, that value is output for CPU addresses 8000-9FFF.
- R3: A write to 9002 sets the swap flag to `cpu_data[1]`, and the other data bits are ignored. With the flag set, the first PRG register is output for C000-DFFF and PRG_ROM_BANKS-2 is output for 8000-9FFF. With the flag clear, the first PRG register serves 8000-9FFF and PRG_ROM_BANKS-2 serves C000-DFFF.
- R4: A write to A000 loads `cpu_data[7:0]` into the second PRG register, which is output for CPU addresses A000-BFFF in both swap modes.
- R5: A write to 9000 sets `mirror` to `cpu_data[1:0]`, where 0 is vertical, 1 is horizontal, 2 is single-screen page 0 and 3 is single-screen page 1. The upper data bits are ignored.
- R6: Writes to addresses B000-E003 whose low nibble is 0 to 3 target CHR register index (address[15:12] - 0xB)*2 + address[1].
- R7: A CHR write at an even address (address[0]=0) replaces bits 3:0 of the target 9-bit bank with `cpu_data[3:0]` and keeps bits 8:4. A write at an odd address replaces bits 8:4 with `cpu_data[4:0]` and keeps bits 3:0.
- R8: For CPU addresses E000-FFFF, `prg_bank` is PRG_ROM_BANKS-1 regardless of any register.
- R9: Register selection looks only at address bits 15:12 and 3:0, so bits 11:4 do not matter (for example, 8FF0 acts as 8000 and B7F1 acts as B001).
- R10: A write that matches no register changes no output. This includes writes with `cpu_wr` low, writes below 8000, writes to F000-FFFF, writes to 8001, 9001, 9003 and A004, and CHR-range writes with a low nibble of 4 or more.
- R11: `chr_bank` is the CHR register chosen by `ppu_addr[12:10]`. Other PPU address bits have no effect. `prg_bank` is 0 for CPU addresses below 8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one register write per high cycle |
| cpu_addr | input | 16 | CPU address, used for register decode and PRG lookup |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address for the CHR lookup |
| prg_bank | output | 8 | 8 KiB PRG ROM bank for `cpu_addr` |
| chr_bank | output | 9 | 1 KiB CHR bank for `ppu_addr` |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that `cpu_addr` and `cpu_data` hold known, steady values through any cycle where `cpu_wr` is high, and that at most one register is written per clock. They do not assume any spacing between writes. The bench drives inputs only on the falling edge and raises `cpu_wr` for exactly one cycle per write, so both assumptions hold. Between writes it changes `cpu_addr` and `ppu_addr` freely with the strobe low, which is when the assertions check that all registers stay unchanged.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int PRG_W    = 8;
  localparam int CHR_LO_W = 4;
  localparam int CHR_HI_W = 5;
  localparam int CHR_W    = CHR_LO_W + CHR_HI_W;
  localparam int CHR_REGS = 8;
  localparam int IDX_W    = $clog2(CHR_REGS);
  localparam int MIR_W    = 2;

  typedef logic [CHR_W-1:0] chr_num_t;

  typedef struct packed {
    logic             prg_a;
    logic             prg_b;
    logic             swap;
    logic             mirror;
    logic             chr_lo;
    logic             chr_hi;
    logic [IDX_W-1:0] chr_idx;
  } wr_evt_t;

  // CHR register index from the top address nibble and address bit 1
  function automatic logic [IDX_W-1:0] chr_index(input logic [3:0] hi_nib, input logic a1);
    logic [3:0] rel;
    rel = hi_nib - 4'hB;
    return {rel[IDX_W-2:0], a1};
  endfunction

  // Replace the low part of a CHR number
  function automatic chr_num_t merge_lo(input chr_num_t old, input logic [CHR_LO_W-1:0] v);
    return {old[CHR_W-1:CHR_LO_W], v};
  endfunction

  // Replace the high part of a CHR number
  function automatic chr_num_t merge_hi(input chr_num_t old, input logic [CHR_HI_W-1:0] v);
    return {v, old[CHR_LO_W-1:0]};
  endfunction
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_bank_pkg::*;
(
  input  logic          cpu_wr,
  input  logic [3:0]    addr_hi,
  input  logic [3:0]    addr_lo,
  output wr_evt_t       evt
);
  logic in_chr_range;
  logic lo_small;

  assign in_chr_range = (addr_hi >= 4'hB) && (addr_hi <= 4'hE);
  assign lo_small     = (addr_lo[3:2] == 2'b00);

  always_comb begin
    evt         = '0;
    evt.chr_idx = chr_index(addr_hi, addr_lo[1]);
    if (cpu_wr) begin
      evt.prg_a  = (addr_hi == 4'h8) && (addr_lo == 4'h0);
      evt.mirror = (addr_hi == 4'h9) && (addr_lo == 4'h0);
      evt.swap   = (addr_hi == 4'h9) && (addr_lo == 4'h2);
      evt.prg_b  = (addr_hi == 4'hA) && (addr_lo == 4'h0);
      evt.chr_lo = in_chr_range && lo_small && !addr_lo[0];
      evt.chr_hi = in_chr_range && lo_small &&  addr_lo[0];
    end
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  wr_evt_t                 evt,
  input  logic [PRG_W-1:0]        data,
  output logic [PRG_W-1:0]        prg_a_q,
  output logic [PRG_W-1:0]        prg_b_q,
  output logic                    swap_q,
  output logic [MIR_W-1:0]        mirror_q,
  output chr_num_t                chr_q [CHR_REGS]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_a_q  <= '0;
      prg_b_q  <= '0;
      swap_q   <= 1'b0;
      mirror_q <= '0;
    end else begin
      if (evt.prg_a)  prg_a_q  <= data;
      if (evt.prg_b)  prg_b_q  <= data;
      if (evt.swap)   swap_q   <= data[1];
      if (evt.mirror) mirror_q <= data[MIR_W-1:0];
    end
  end

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr
    logic hit;
    assign hit = (evt.chr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        chr_q[g] <= '0;
      else if (hit && evt.chr_lo)
        chr_q[g] <= merge_lo(chr_q[g], data[CHR_LO_W-1:0]);
      else if (hit && evt.chr_hi)
        chr_q[g] <= merge_hi(chr_q[g], data[CHR_HI_W-1:0]);
    end
  end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_bank_pkg::*;
#(
  parameter int PRG_ROM_BANKS = 32
) (
  input  logic [2:0]       win,
  input  logic [PRG_W-1:0] prg_a_q,
  input  logic [PRG_W-1:0] prg_b_q,
  input  logic             swap_q,
  output logic [PRG_W-1:0] prg_bank
);
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_ROM_BANKS - 1);
  localparam logic [PRG_W-1:0] NEXT_LAST = PRG_W'(PRG_ROM_BANKS - 2);

  always_comb begin
    prg_bank = '0;
    if (win[2]) begin
      unique case (win[1:0])
        2'd0: prg_bank = swap_q ? NEXT_LAST : prg_a_q;
        2'd1: prg_bank = prg_b_q;
        2'd2: prg_bank = swap_q ? prg_a_q : NEXT_LAST;
        default: prg_bank = LAST_BANK;
      endcase
    end
  end
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_bank_pkg::*;
(
  input  logic [IDX_W-1:0] slice,
  input  chr_num_t         chr_q [CHR_REGS],
  output chr_num_t         chr_bank
);
  assign chr_bank = chr_q[slice];
endmodule

// File: rtl/cart_bank_unit.sv
module cart_bank_unit
  import cart_bank_pkg::*;
#(
  parameter int PRG_ROM_BANKS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr,
  input  logic [15:0]         cpu_addr,
  input  logic [PRG_W-1:0]    cpu_data,
  input  logic [13:0]         ppu_addr,
  output logic [PRG_W-1:0]    prg_bank,
  output logic [CHR_W-1:0]    chr_bank,
  output logic [MIR_W-1:0]    mirror
);
  wr_evt_t          wr_evt;
  logic [PRG_W-1:0] prg_a_q;
  logic [PRG_W-1:0] prg_b_q;
  logic             swap_q;
  chr_num_t         chr_q [CHR_REGS];
  logic [CHR_REGS*CHR_W-1:0] chr_flat;
  logic             unused_bits;

  assign unused_bits = ^{cpu_addr[11:4], ppu_addr[13], ppu_addr[9:0]};

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_flat
    assign chr_flat[g*CHR_W +: CHR_W] = chr_q[g];
  end

  cart_wr_decode u_dec (
    .cpu_wr  (cpu_wr),
    .addr_hi (cpu_addr[15:12]),
    .addr_lo (cpu_addr[3:0]),
    .evt     (wr_evt)
  );

  cart_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (wr_evt),
    .data     (cpu_data),
    .prg_a_q  (prg_a_q),
    .prg_b_q  (prg_b_q),
    .swap_q   (swap_q),
    .mirror_q (mirror),
    .chr_q    (chr_q)
  );

  cart_prg_map #(.PRG_ROM_BANKS(PRG_ROM_BANKS)) u_prg (
    .win      (cpu_addr[15:13]),
    .prg_a_q  (prg_a_q),
    .prg_b_q  (prg_b_q),
    .swap_q   (swap_q),
    .prg_bank (prg_bank)
  );

  cart_chr_map u_chr (
    .slice    (ppu_addr[12:10]),
    .chr_q    (chr_q),
    .chr_bank (chr_bank)
  );
endmodule

// File: rtl/cart_bank_unit_chk.sv
module cart_bank_unit_chk
  import cart_bank_pkg::*;
#(
  parameter int PRG_ROM_BANKS = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cpu_wr,
  input logic [15:0]               cpu_addr,
  input logic [PRG_W-1:0]          cpu_data,
  input logic [PRG_W-1:0]          prg_bank,
  input logic [MIR_W-1:0]          mirror,
  input wr_evt_t                   evt,
  input logic [PRG_W-1:0]          prg_a_q,
  input logic [PRG_W-1:0]          prg_b_q,
  input logic                      swap_q,
  input logic [CHR_REGS*CHR_W-1:0] chr_flat
);
  // R10
  quiet_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> (evt.prg_a == 1'b0 && evt.prg_b == 1'b0 && evt.swap == 1'b0 &&
                 evt.mirror == 1'b0 && evt.chr_lo == 1'b0 && evt.chr_hi == 1'b0));

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.prg_a, evt.prg_b, evt.swap, evt.mirror, evt.chr_lo, evt.chr_hi}));

  // R2
  prg_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.prg_a |=> prg_a_q == $past(cpu_data));

  // R4
  prg_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.prg_b |=> prg_b_q == $past(cpu_data));

  // R3
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.swap |=> swap_q == $past(cpu_data[1]));

  // R5
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mirror |=> mirror == $past(cpu_data[MIR_W-1:0]));

  // R7
  chr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.chr_lo |=> chr_flat[32'($past(evt.chr_idx))*CHR_W +: CHR_LO_W] == $past(cpu_data[CHR_LO_W-1:0]));

  // R7
  chr_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.chr_hi |=> chr_flat[32'($past(evt.chr_idx))*CHR_W + CHR_LO_W +: CHR_HI_W] == $past(cpu_data[CHR_HI_W-1:0]));

  // R10
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(prg_a_q) && $stable(prg_b_q) && $stable(swap_q) &&
                 $stable(mirror) && $stable(chr_flat)));

  // R8
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> prg_bank == PRG_W'(PRG_ROM_BANKS - 1));
endmodule

bind cart_bank_unit cart_bank_unit_chk #(.PRG_ROM_BANKS(PRG_ROM_BANKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .cpu_addr (cpu_addr),
  .cpu_data (cpu_data),
  .prg_bank (prg_bank),
  .mirror   (mirror),
  .evt      (wr_evt),
  .prg_a_q  (prg_a_q),
  .prg_b_q  (prg_b_q),
  .swap_q   (swap_q),
  .chr_flat (chr_flat)
);

// File: tb/test_cart_bank_unit.sv
module test_cart_bank_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_BANKS  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [13:0] ppu_addr = '0;
  logic [7:0]  prg_bank;
  logic [8:0]  chr_bank;
  logic [1:0]  mirror;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side model of the register state
  logic [7:0] m_p0 = '0;
  logic [7:0] m_p1 = '0;
  bit         m_swap = 1'b0;
  logic [1:0] m_mir = '0;
  logic [8:0] m_chr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_unit #(.PRG_ROM_BANKS(ROM_BANKS)) i_cart_bank_unit (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .mirror(mirror)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_prg(input logic [15:0] a);
    if (!a[15]) return 0;
    case (a[14:13])
      2'd0: return m_swap ? ROM_BANKS - 2 : int'(m_p0);
      2'd1: return int'(m_p1);
      2'd2: return m_swap ? int'(m_p0) : ROM_BANKS - 2;
      default: return ROM_BANKS - 1;
    endcase
  endfunction

  // model update from the requirement text
  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int top;
    int lo;
    int idx;
    top = int'(a[15:12]);
    lo  = int'(a[3:0]);
    if (top == 8 && lo == 0) m_p0 = d;
    if (top == 9 && lo == 0) m_mir = d[1:0];
    if (top == 9 && lo == 2) m_swap = d[1];
    if (top == 10 && lo == 0) m_p1 = d;
    if (top >= 11 && top <= 14 && lo < 4) begin
      idx = (top - 11) * 2 + (lo / 2) % 2;
      if (lo % 2 == 0) m_chr[idx] = {m_chr[idx][8:4], d[3:0]};
      else             m_chr[idx] = {d[4:0], m_chr[idx][3:0]};
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr   = 1'b1;
    @(negedge clk);
    cpu_wr   = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] probes [5];
    probes[0] = 16'h8123; probes[1] = 16'hB456; probes[2] = 16'hC789;
    probes[3] = 16'hFFFE; probes[4] = 16'h6000;
    for (int i = 0; i < 5; i++) begin
      cpu_addr = probes[i];
      #1;
      check({tag, " prg"}, int'(prg_bank), exp_prg(probes[i]));
    end
    for (int s = 0; s < 8; s++) begin
      ppu_addr = {s[0] ^ s[1], s[2:0], 10'(s * 97 + 5)};
      #1;
      check({tag, " chr R11"}, int'(chr_bank), int'(m_chr[s]));
    end
    check({tag, " mirror"}, int'(mirror), int'(m_mir));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R5: every mirroring code, upper data bits junk
    for (int m = 0; m < 4; m++) begin
      do_write(16'h9000, 8'(8'hA8 | m));
      check_all("R5 mirror");
    end

    // R2 R4 R8: PRG register values across the range
    for (int v = 0; v < 256; v += 17) begin
      do_write(16'h8000, 8'(v));
      do_write(16'hA000, 8'(255 - v));
      check_all("R2 R4 R8 prg");
    end

    // R3: swap flag from data bit 1 only
    do_write(16'h9002, 8'h02); check_all("R3 swap on");
    do_write(16'h8000, 8'h5A); check_all("R3 swapped load");
    do_write(16'h9002, 8'hFD); check_all("R3 swap off");
    do_write(16'h9002, 8'hFF); check_all("R3 swap on again");
    do_write(16'h9002, 8'h01); check_all("R3 swap off again");

    // R6 R7: exhaustive CHR address sweep
    for (int top = 11; top <= 14; top++) begin
      for (int lo = 0; lo < 4; lo++) begin
        do_write(16'(top * 4096 + lo), 8'(top * 37 + lo * 11 + 3));
        check_all("R6 R7 chr");
      end
    end
    for (int top = 11; top <= 14; top++) begin
      do_write(16'(top * 4096 + 1), 8'hFF);
      check_all("R7 hi keeps lo");
      do_write(16'(top * 4096 + 2), 8'h0C);
      check_all("R7 lo keeps hi");
    end

    // R9: address bits 11:4 ignored
    do_write(16'h8FF0, 8'h33); check_all("R9 alias 8000");
    do_write(16'hAAB0, 8'h44); check_all("R9 alias A000");
    do_write(16'h9FF2, 8'h02); check_all("R9 alias 9002");
    do_write(16'h9550, 8'h03); check_all("R9 alias 9000");
    do_write(16'hB7F1, 8'h15); check_all("R9 alias B001");
    do_write(16'hE8A2, 8'h09); check_all("R9 alias E002");

    // R10: non-matching writes change nothing
    begin
      logic [15:0] junk [12];
      junk[0] = 16'h8001; junk[1] = 16'h9001; junk[2] = 16'h9003;
      junk[3] = 16'hA004; junk[4] = 16'hB004; junk[5] = 16'hF000;
      junk[6] = 16'hF001; junk[7] = 16'hF002; junk[8] = 16'hF003;
      junk[9] = 16'h7000; junk[10] = 16'h1000; junk[11] = 16'hD00F;
      for (int j = 0; j < 12; j++) begin
        do_write(junk[j], 8'hE7);
        check_all("R10 unused");
      end
      // strobe low with a matching address
      @(negedge clk);
      cpu_addr = 16'h8000; cpu_data = 8'h99; cpu_wr = 1'b0;
      @(negedge clk);
      check_all("R10 strobe low");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule